// File: doc/BRIEF.md
# Disturb-Avoiding Compressed Line Controller

This block looks after a single 64-byte cache data line held in a cell array where sensing a cell can corrupt it. A write request brings an already compressed payload, its compressed width in bytes and the encoding that produced it. From the width alone the controller picks a storage layout:

- a zero width keeps nothing in the array at all;
- a width of up to half a line is stored twice, once in each half;
- anything wider is stored once from byte 0.

On a read it chooses which copy to sense. It returns the compressed bytes aligned to byte 0, with the stored encoding and width beside them. It issues a restore write only when the copy it just sensed was the last clean one.

The cell array sits inside the block as a register array. A read strobe inverts every byte it senses, which models the disturbance. The sensed value is held in a sense register and written back on the cycle after the read. A write arriving in that cycle takes priority and the restore is dropped. Read data is observable one cycle after an accepted read. The array strobes and byte mask are brought out as ports so that the access pattern can be watched from outside.

Top module: `lc_line_ctrl`

## Requirements
- R1: After reset the line reads back as width 0 and encoding 0 with all-zero data, no array strobe is active, and `rd_ready` is high.
- R2: A write of width 0 raises no array write strobe and drives an all-zero byte mask. Every later read of that line returns zero data with the stored encoding and never raises the array read or restore strobe.
- R3: A write of width w with 0 < w <= 32 raises the array write strobe once. Its byte mask covers bytes 0..w-1 and 32..32+w-1, and both ranges receive the same payload bytes.
- R4: The first read after a two-copy write senses bytes 0..w-1 and issues no restore in the following cycle.
- R5: Every further read of a two-copy line senses bytes 32..32+w-1 and issues a restore with that same byte mask in the following cycle.
- R6: A write of width w > 32 stores one copy in bytes 0..w-1. Every read of it senses those bytes and is followed by a restore with that mask in the next cycle.
- R7: A restore occurs only in the cycle after an array read. Its mask holds exactly w bytes, and repeated reads keep returning the written payload despite the inverting disturbance.
- R8: Every write resets the copy tracking, so a new two-copy write again starts with a restore-free read of bytes 0..w-1.
- R9: A write issued in the cycle where a restore is pending cancels the restore. The arrest strobe stays low and the new data is stored.
- R10: `rd_valid` rises in the cycle after an accepted read. `rd_data` then carries the w sensed bytes at bytes 0..w-1, with zeros above, and `rd_enc`/`rd_cw` carry the stored encoding and width.
- R11: While a restore is pending, `rd_ready` is low and a read request has no effect: no array read, and no `rd_valid` in the next cycle.
- R12: When read and write are requested in the same cycle the write is performed, the read is ignored (no array read, no `rd_valid` next cycle), and the following read sees the new line.
- R13: At most one of the array read, write and restore strobes is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write request for the line |
| wr_enc | input | ENC_W | Compression encoding of the written data |
| wr_cw | input | CW_W | Compressed width in bytes (clamped to the line size) |
| wr_data | input | LINE_BYTES*8 | Compressed payload, valid in bytes 0..wr_cw-1 |
| rd_req | input | 1 | Read request for the line |
| rd_ready | output | 1 | Low while a restore is pending; reads are then ignored |
| rd_valid | output | 1 | Read result valid, one cycle after an accepted read |
| rd_enc | output | ENC_W | Stored encoding returned with the read |
| rd_cw | output | CW_W | Stored compressed width returned with the read |
| rd_data | output | LINE_BYTES*8 | Sensed compressed bytes aligned to byte 0, zero above the width |
| arr_rd | output | 1 | Array sense strobe |
| arr_wr | output | 1 | Array write strobe for a normal write |
| arr_rst | output | 1 | Array restore strobe |
| arr_mask | output | LINE_BYTES | Byte mask of the active array strobe |

## Verification
The bound checker watches, on every cycle:
- that the array strobes are exclusive;
- that a restore only follows a sense and spans exactly the stored width;
- that a two-copy write covers twice the width;
- that an empty line is never sensed;
- that the first read of a two-copy line is restore-free while a single-copy read is always restored unless a write cancels it;
- the handshake rules on `rd_valid`.

Only the bench scenarios can show what the data looks like. They confirm that the payload survives repeated disturbing reads, that the two copies sit in the correct halves, and that a cancelled restore leaves the new line intact. They also confirm that the copy tracking restarts on each write, across every width from 0 to 64.

// File: rtl/lc_pkg.sv
package lc_pkg;
  // Copy status of the stored line
  typedef enum logic [1:0] {
    CP_EMPTY = 2'd0,  // nothing in the array (zero width)
    CP_PAIR  = 2'd1,  // two clean copies, low and high half
    CP_LAST  = 2'd2,  // low copy disturbed, high copy clean
    CP_SOLO  = 2'd3   // one wide copy from byte 0
  } copy_st_e;
endpackage

// File: rtl/lc_copy_policy.sv
module lc_copy_policy #(
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned CW_W       = 7
) (
  input  lc_pkg::copy_st_e st,
  input  logic [CW_W-1:0]  wr_cw,
  output logic             touch,
  output logic             sense_hi,
  output logic             need_rst,
  output lc_pkg::copy_st_e st_rd,
  output lc_pkg::copy_st_e st_wr,
  output logic             twin
);
  import lc_pkg::*;
  localparam int unsigned HALF = LINE_BYTES / 2;

  always_comb begin
    touch    = (st != CP_EMPTY);
    sense_hi = (st == CP_LAST);
    need_rst = (st == CP_LAST) || (st == CP_SOLO);
    st_rd    = (st == CP_PAIR) ? CP_LAST : st;
    twin     = (wr_cw != '0) && (wr_cw <= CW_W'(HALF));
    if (wr_cw == '0)  st_wr = CP_EMPTY;
    else if (twin)    st_wr = CP_PAIR;
    else              st_wr = CP_SOLO;
  end
endmodule

// File: rtl/lc_cell_array.sv
module lc_cell_array #(
  parameter int unsigned LINE_BYTES = 64,
  localparam int unsigned DW = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [LINE_BYTES-1:0] wr_mask,
  input  logic [DW-1:0]         wr_line,
  input  logic                  rd_en,
  input  logic [LINE_BYTES-1:0] rd_mask,
  output logic [DW-1:0]         rd_line
);
  // One byte of cells per generate step; a sense inverts the bytes it covers.
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    logic [7:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cell_q <= '0;
      else if (wr_en && wr_mask[b])   cell_q <= wr_line[b*8 +: 8];
      else if (rd_en && rd_mask[b])   cell_q <= ~cell_q;
    end
    assign rd_line[b*8 +: 8] = cell_q;
  end
endmodule

// File: rtl/lc_sense_latch.sv
module lc_sense_latch #(
  parameter int unsigned DW = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] cap_line,
  input  logic          cap_hi,
  output logic [DW-1:0] held_line,
  output logic          held_hi,
  output logic          pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_line <= '0;
      held_hi   <= 1'b0;
      pend      <= 1'b0;
    end else begin
      pend <= cap;  // a restore lives for exactly one cycle
      if (cap) begin
        held_line <= cap_line;
        held_hi   <= cap_hi;
      end
    end
  end
endmodule

// File: rtl/lc_line_ctrl.sv
module lc_line_ctrl #(
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned ENC_W      = 4,
  localparam int unsigned CW_W = $clog2(LINE_BYTES + 1),
  localparam int unsigned DW   = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_req,
  input  logic [ENC_W-1:0]      wr_enc,
  input  logic [CW_W-1:0]       wr_cw,
  input  logic [DW-1:0]         wr_data,
  input  logic                  rd_req,
  output logic                  rd_ready,
  output logic                  rd_valid,
  output logic [ENC_W-1:0]      rd_enc,
  output logic [CW_W-1:0]       rd_cw,
  output logic [DW-1:0]         rd_data,
  output logic                  arr_rd,
  output logic                  arr_wr,
  output logic                  arr_rst,
  output logic [LINE_BYTES-1:0] arr_mask
);
  import lc_pkg::*;
  localparam int unsigned HALF = LINE_BYTES / 2;

  // ---------------- arithmetic helpers ----------------
  function automatic logic [LINE_BYTES-1:0] span_mask(input logic [CW_W-1:0] n,
                                                      input logic hi);
    int unsigned lo;
    lo = hi ? HALF : 0;
    for (int unsigned i = 0; i < LINE_BYTES; i++)
      span_mask[i] = (i >= lo) && (i < lo + int'(n));
  endfunction

  function automatic logic [DW-1:0] keep_bytes(input logic [DW-1:0] line,
                                               input logic [CW_W-1:0] n);
    for (int unsigned i = 0; i < LINE_BYTES; i++)
      keep_bytes[i*8 +: 8] = (i < int'(n)) ? line[i*8 +: 8] : 8'h00;
  endfunction

  function automatic logic [DW-1:0] lift(input logic [DW-1:0] line, input logic hi);
    lift = hi ? (line << (HALF * 8)) : line;
  endfunction

  function automatic logic [DW-1:0] drop(input logic [DW-1:0] line, input logic hi);
    drop = hi ? (line >> (HALF * 8)) : line;
  endfunction

  // ---------------- stored line state ----------------
  copy_st_e         st_q;
  logic [CW_W-1:0]  cw_q;
  logic [ENC_W-1:0] enc_q;

  // ---------------- named internal events ----------------
  logic             ev_rd_acc;   // read accepted this cycle
  logic             ev_arr_rd;   // array sensed this cycle
  logic             ev_wr_go;    // array written by a normal write
  logic             ev_rst_go;   // restore written this cycle
  logic             ev_pend;     // restore pending
  logic [CW_W-1:0]  ev_cw_in;    // clamped write width
  copy_st_e         ev_st;
  logic [CW_W-1:0]  ev_cw;

  // policy
  logic     pol_touch, pol_hi, pol_need_rst, pol_twin;
  copy_st_e pol_st_rd, pol_st_wr;

  assign ev_cw_in = (wr_cw > CW_W'(LINE_BYTES)) ? CW_W'(LINE_BYTES) : wr_cw;

  lc_copy_policy #(.LINE_BYTES(LINE_BYTES), .CW_W(CW_W)) u_policy (
    .st       (st_q),
    .wr_cw    (ev_cw_in),
    .touch    (pol_touch),
    .sense_hi (pol_hi),
    .need_rst (pol_need_rst),
    .st_rd    (pol_st_rd),
    .st_wr    (pol_st_wr),
    .twin     (pol_twin)
  );

  // sense latch
  logic [DW-1:0] held_line;
  logic          held_hi;
  logic [DW-1:0] arr_line;
  logic [DW-1:0] sensed;

  assign ev_rd_acc = rd_req && !wr_req && !ev_pend;
  assign ev_arr_rd = ev_rd_acc && pol_touch;
  assign ev_wr_go  = wr_req && (ev_cw_in != '0);
  assign ev_rst_go = ev_pend && !wr_req;
  assign ev_st     = st_q;
  assign ev_cw     = cw_q;

  assign sensed = keep_bytes(drop(arr_line, pol_hi), cw_q);

  lc_sense_latch #(.DW(DW)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap       (ev_arr_rd && pol_need_rst),
    .cap_line  (sensed),
    .cap_hi    (pol_hi),
    .held_line (held_line),
    .held_hi   (held_hi),
    .pend      (ev_pend)
  );

  // write and restore images
  logic [LINE_BYTES-1:0] wmask, rmask, rst_mask, a_wmask;
  logic [DW-1:0]         wline, rst_line, a_wline;
  logic [DW-1:0]         payload;

  always_comb begin
    payload  = keep_bytes(wr_data, ev_cw_in);
    wline    = payload | (pol_twin ? lift(payload, 1'b1) : '0);
    wmask    = span_mask(ev_cw_in, 1'b0) | (pol_twin ? span_mask(ev_cw_in, 1'b1) : '0);
    rmask    = span_mask(cw_q, pol_hi);
    rst_mask = span_mask(cw_q, held_hi);
    rst_line = lift(held_line, held_hi);
    a_wmask  = ev_wr_go ? wmask : rst_mask;
    a_wline  = ev_wr_go ? wline : rst_line;
  end

  lc_cell_array #(.LINE_BYTES(LINE_BYTES)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ev_wr_go || ev_rst_go),
    .wr_mask (a_wmask),
    .wr_line (a_wline),
    .rd_en   (ev_arr_rd),
    .rd_mask (rmask),
    .rd_line (arr_line)
  );

  // ---------------- state and read result ----------------
  logic             rd_valid_q;
  logic [DW-1:0]    rd_data_q;
  logic [ENC_W-1:0] rd_enc_q;
  logic [CW_W-1:0]  rd_cw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= CP_EMPTY;
      cw_q       <= '0;
      enc_q      <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      rd_enc_q   <= '0;
      rd_cw_q    <= '0;
    end else begin
      rd_valid_q <= ev_rd_acc;
      if (wr_req) begin
        st_q  <= pol_st_wr;
        cw_q  <= ev_cw_in;
        enc_q <= wr_enc;
      end else if (ev_arr_rd) begin
        st_q <= pol_st_rd;
      end
      if (ev_rd_acc) begin
        rd_data_q <= pol_touch ? sensed : '0;
        rd_enc_q  <= enc_q;
        rd_cw_q   <= cw_q;
      end
    end
  end

  assign rd_ready = !ev_pend;
  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
  assign rd_enc   = rd_enc_q;
  assign rd_cw    = rd_cw_q;
  assign arr_rd   = ev_arr_rd;
  assign arr_wr   = ev_wr_go;
  assign arr_rst  = ev_rst_go;
  assign arr_mask = ev_arr_rd ? rmask : (ev_wr_go ? wmask : (ev_rst_go ? rst_mask : '0));
endmodule

// File: rtl/lc_line_ctrl_chk.sv
module lc_line_ctrl_chk #(
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned CW_W       = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_req,
  input logic                  rd_req,
  input logic                  rd_ready,
  input logic                  rd_valid,
  input logic                  arr_rd,
  input logic                  arr_wr,
  input logic                  arr_rst,
  input logic [LINE_BYTES-1:0] arr_mask,
  input logic                  ev_rd_acc,
  input lc_pkg::copy_st_e      ev_st,
  input logic [CW_W-1:0]       ev_cw,
  input logic [CW_W-1:0]       ev_cw_in
);
  import lc_pkg::*;
  localparam int unsigned HALF = LINE_BYTES / 2;

  assert_one_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_rd, arr_wr, arr_rst}));

  assert_restore_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rst |-> $past(arr_rd));

  assert_restore_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rst |-> ($countones(arr_mask) == int'(ev_cw)));

  assert_empty_no_sense_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_st == CP_EMPTY) |-> !arr_rd);

  assert_pair_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr && (ev_cw_in <= CW_W'(HALF))) |-> ($countones(arr_mask) == 2 * int'(ev_cw_in)));

  assert_pair_no_restore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_rd && ev_st == CP_PAIR) |=> !arr_rst);

  assert_solo_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_rd && ev_st == CP_SOLO) |=> (arr_rst || wr_req));

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_acc |=> rd_valid);

  assert_busy_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ready) |=> !rd_valid);

  assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && wr_req) |=> !rd_valid);
endmodule

bind lc_line_ctrl lc_line_ctrl_chk #(.LINE_BYTES(LINE_BYTES), .CW_W(CW_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_req    (wr_req),
  .rd_req    (rd_req),
  .rd_ready  (rd_ready),
  .rd_valid  (rd_valid),
  .arr_rd    (arr_rd),
  .arr_wr    (arr_wr),
  .arr_rst   (arr_rst),
  .arr_mask  (arr_mask),
  .ev_rd_acc (ev_rd_acc),
  .ev_st     (ev_st),
  .ev_cw     (ev_cw),
  .ev_cw_in  (ev_cw_in)
);

// File: tb/test_lc_line_ctrl.sv
`timescale 1ns/1ps
module test_lc_line_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_req = 1'b0;
  logic [3:0]   wr_enc = '0;
  logic [6:0]   wr_cw = '0;
  logic [511:0] wr_data = '0;
  logic         rd_req = 1'b0;
  logic         rd_ready, rd_valid, arr_rd, arr_wr, arr_rst;
  logic [3:0]   rd_enc;
  logic [6:0]   rd_cw;
  logic [511:0] rd_data;
  logic [63:0]  arr_mask;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  lc_line_ctrl i_lc_line_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_enc(wr_enc), .wr_cw(wr_cw),
    .wr_data(wr_data), .rd_req(rd_req), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_enc(rd_enc), .rd_cw(rd_cw), .rd_data(rd_data), .arr_rd(arr_rd),
    .arr_wr(arr_wr), .arr_rst(arr_rst), .arr_mask(arr_mask)
  );

  function automatic logic [511:0] pay(int cw, int seed);
    logic [511:0] v = '0;
    for (int i = 0; i < cw; i++) v[i*8 +: 8] = 8'((i * 37 + seed * 11 + cw + 1));
    return v;
  endfunction

  function automatic logic [511:0] dirty(int cw, int seed);
    logic [511:0] v = pay(cw, seed);
    for (int i = cw; i < 64; i++) v[i*8 +: 8] = 8'hA5;
    return v;
  endfunction

  function automatic logic [63:0] emask(int n, int base);
    logic [63:0] m = '0;
    for (int i = 0; i < 64; i++) m[i] = (i >= base) && (i < base + n);
    return m;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [511:0] act,
                     input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int cw, input int enc, input int seed);
    logic [63:0] m;
    @(negedge clk);
    wr_req = 1'b1; wr_cw = 7'(cw); wr_enc = 4'(enc); wr_data = dirty(cw, seed);
    #1;
    if (cw == 0)       m = '0;
    else if (cw <= 32) m = emask(cw, 0) | emask(cw, 32);
    else               m = emask(cw, 0);
    chk(arr_wr == (cw != 0), "R2/R3/R6 write strobe", 512'(arr_wr), 512'(cw != 0));
    chk(arr_mask == m, (cw <= 32) ? "R3 write mask" : "R6 write mask", 512'(arr_mask), 512'(m));
    @(negedge clk);
    wr_req = 1'b0;
  endtask

  task automatic rd(input int cw, input int enc, input int seed, input int base,
                    input bit exp_rst, input string tag);
    logic [63:0] m;
    m = (cw == 0) ? 64'd0 : emask(cw, base);
    @(negedge clk);
    rd_req = 1'b1;
    #1;
    chk(arr_rd == (cw != 0), {tag, " sense strobe"}, 512'(arr_rd), 512'(cw != 0));
    chk(arr_mask == m, {tag, " sense mask"}, 512'(arr_mask), 512'(m));
    @(negedge clk);
    rd_req = 1'b0;
    #1;
    chk(rd_valid == 1'b1, "R10 rd_valid", 512'(rd_valid), 512'(1));
    chk(rd_data == pay(cw, seed), {tag, " R7 R10 data"}, rd_data, pay(cw, seed));
    chk(rd_enc == 4'(enc) && rd_cw == 7'(cw), "R10 enc/width", 512'({rd_enc, rd_cw}),
        512'({4'(enc), 7'(cw)}));
    chk(arr_rst == exp_rst, {tag, " restore strobe"}, 512'(arr_rst), 512'(exp_rst));
    if (exp_rst)
      chk(arr_mask == m, "R7 restore mask", 512'(arr_mask), 512'(m));
    chk(rd_ready == !exp_rst, "R11 rd_ready", 512'(rd_ready), 512'(!exp_rst));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk({arr_rd, arr_wr, arr_rst} == 3'b000 && rd_ready && !rd_valid, "R1 reset strobes",
        512'({arr_rd, arr_wr, arr_rst, rd_ready, rd_valid}), 512'(5'b00010));
    rd(0, 0, 0, 0, 1'b0, "R1 reset read");

    // Sweep of every width, two payload seeds; R8 re-write restarts tracking
    for (int s = 0; s < 2; s++) begin
      for (int cw = 0; cw <= 64; cw++) begin
        wr(cw, (cw + s) % 16, s);
        if (cw == 0) begin
          rd(0, s % 16, s, 0, 1'b0, "R2 empty read");
          rd(0, s % 16, s, 0, 1'b0, "R2 empty read");
        end else if (cw <= 32) begin
          rd(cw, (cw + s) % 16, s, 0, 1'b0, "R4 R8 first pair read");
          rd(cw, (cw + s) % 16, s, 32, 1'b1, "R5 second pair read");
          rd(cw, (cw + s) % 16, s, 32, 1'b1, "R5 third pair read");
        end else begin
          rd(cw, (cw + s) % 16, s, 0, 1'b1, "R6 solo read");
          rd(cw, (cw + s) % 16, s, 0, 1'b1, "R6 solo read");
          rd(cw, (cw + s) % 16, s, 0, 1'b1, "R6 solo read");
        end
      end
    end

    // R9: write during pending restore cancels it
    wr(50, 3, 4);
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    wr_req = 1'b1; wr_cw = 7'd20; wr_enc = 4'd9; wr_data = dirty(20, 5);
    #1;
    chk(arr_rst == 1'b0, "R9 restore cancelled", 512'(arr_rst), 512'(0));
    chk(arr_wr == 1'b1, "R9 write taken", 512'(arr_wr), 512'(1));
    @(negedge clk);
    wr_req = 1'b0;
    rd(20, 9, 5, 0, 1'b0, "R9 R8 after cancel");
    rd(20, 9, 5, 32, 1'b1, "R9 second read");

    // R11: read request while restore pending is ignored
    wr(40, 6, 7);
    @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk);
    #1;
    chk(rd_ready == 1'b0, "R11 busy", 512'(rd_ready), 512'(0));
    chk(arr_rd == 1'b0 && arr_rst == 1'b1, "R11 no sense while pending",
        512'({arr_rd, arr_rst}), 512'(2'b01));
    @(negedge clk);
    rd_req = 1'b0;
    #1;
    chk(rd_valid == 1'b0, "R11 ignored read", 512'(rd_valid), 512'(0));
    rd(40, 6, 7, 0, 1'b1, "R11 R7 after busy");

    // R12: simultaneous write and read
    @(negedge clk);
    wr_req = 1'b1; rd_req = 1'b1; wr_cw = 7'd10; wr_enc = 4'd12; wr_data = dirty(10, 8);
    #1;
    chk(arr_rd == 1'b0 && arr_wr == 1'b1, "R12 write wins", 512'({arr_rd, arr_wr}), 512'(2'b01));
    @(negedge clk);
    wr_req = 1'b0; rd_req = 1'b0;
    #1;
    chk(rd_valid == 1'b0, "R12 read ignored", 512'(rd_valid), 512'(0));
    rd(10, 12, 8, 0, 1'b0, "R12 R4 new line");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule